// File: doc/BRIEF.md
# Clock Ratio Control Register

This block is one 32-bit read/write control register on a simple register bus. From its fields it drives four clock-enable streams, one for each peripheral group: two network controllers that share one ratio field, an encryption core and a USB controller. Each stream lets its group's logic advance at the full bus-clock rate, at one half or one third of it, or not at all. The groups keep running on the bus clock and qualify their flops with the enable.

The two network controllers share one 2-bit ratio code. Each also has its own run bit. For the network field, the all-zero code is reserved and acts as full rate. For the encryption and USB fields, the all-zero code stops the stream. The encryption and USB units must use the same ratio whenever both are running. If software stores two different running ratios for them, a sticky error bit in the same register is set, and software clears it by writing a one to that bit.

Ratio changes never cut a divider period short. A divider takes a new ratio, or the stop, only after the pulse that ends its current period.

Top module: `clkratio_ctrl`

## Requirements
- R1: The register answers only at address `REG_ADDR` (default 0xA08). A read from any other address returns 0, and a write to any other address leaves the register unchanged. After reset the register reads 0x0000_044D.
- R2: Bits [1:0], [2], [3], [7:6] and [11:10] store what was written, and a read returns them as written, including a network code of 00. All other bits below 31 read 0 and ignore writes.
- R3: Network ratio code in bits [1:0]: 01 means every cycle, 10 means every 2nd cycle, 11 means every 3rd cycle. Code 00 drives the network enables as 01 does.
- R4: Bit 2 is the run bit of `net0_ce` and bit 3 is the run bit of `net1_ce`. A 0 stops that stream and a 1 runs it at the shared network ratio.
- R5: Bits [7:6] set `crypto_ce` and bits [11:10] set `usb_ce`. Code 00 stops the stream, and 01, 10 and 11 give every cycle, every 2nd cycle and every 3rd cycle.
- R6: At ratio 1:1 an enable is held high. At ratio 1:N (N = 2 or 3) an enable is high for exactly one cycle in every N, so a 12-cycle window holds 12, 6 or 4 high cycles.
- R7: A change of ratio, and a stop, takes effect only after the enable pulse that closes the current period. A stream at 1:3 therefore still delivers its next pulse after a change is written.
- R8: Bit 31 is set one cycle after the stored encryption and USB codes are both non-zero and differ. It stays set until software clears it, even when the conflict goes away.
- R9: A write of 1 to bit 31 clears the flag. If the conflict is still stored, the flag is set again on the next cycle. A write of 0 to bit 31 leaves the flag unchanged.
- R10: No flag is raised when the encryption and USB codes are equal, or when either of them is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all enables are relative to it |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register bus address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for the current address (combinational) |
| net0_ce | output | 1 | Enable stream of the first network controller |
| net1_ce | output | 1 | Enable stream of the second network controller |
| crypto_ce | output | 1 | Enable stream of the encryption core |
| usb_ce | output | 1 | Enable stream of the USB controller |

## Verification
The hardest case to reach is a ratio change or stop written in the middle of a divider period. From the ports, software cannot see the divider's phase, only its pulses. The stimulus puts the network streams at 1:3 and watches `net0_ce` until a pulse appears, which places the write at a known phase. It then checks that one more full-length pulse arrives before the new setting shows. The sticky flag is also driven through every clear-versus-set ordering: a clear while the conflict is still stored, a removal of the conflict without a clear, and a write with bit 31 at zero.

// File: rtl/clkratio_pkg.sv
package clkratio_pkg;

   localparam int RATIO_W      = 2;
   localparam int NUM_GROUPS   = 4;   // net0, net1, crypto, usb
   localparam int NET_GROUPS   = 2;

   // register layout
   localparam int NET_CODE_LSB = 0;
   localparam int NET_ON_LSB   = 2;
   localparam int UNIT_BASE    = 6;
   localparam int UNIT_STRIDE  = 4;
   localparam int FLAG_BIT     = 31;

   localparam logic [31:0] FIELD_MASK  = 32'h0000_0CCF;
   localparam logic [31:0] RESET_VALUE = 32'h0000_044D;

   typedef logic [RATIO_W-1:0] ratio_t;

   // network field: reserved code 00 behaves as 1:1, run bit gates it
   function automatic ratio_t net_ratio(input ratio_t code, input logic run);
      if (!run)
         return '0;
      else if (code == '0)
         return ratio_t'(1);
      else
         return code;
   endfunction

endpackage

// File: rtl/clkratio_divider.sv
module clkratio_divider
   import clkratio_pkg::*;
#(
   parameter int RW = RATIO_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [RW-1:0] ratio_req,
   output logic          ce
);

   localparam int CNT_W = RW;

   logic [CNT_W-1:0] per_q;   // ratio in force for this period, 0 = stopped
   logic [CNT_W-1:0] cnt_q;
   logic             last;
   logic             boundary;

   assign last     = (cnt_q == per_q - CNT_W'(1));
   assign boundary = (per_q == '0) || last;
   assign ce       = (per_q != '0) && last;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         per_q <= '0;
         cnt_q <= '0;
      end else if (boundary) begin
         per_q <= ratio_req;
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   AST_PERIOD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (per_q != '0 && !last) |=> ($stable(per_q) && cnt_q == $past(cnt_q) + CNT_W'(1))); // R7

   AST_CNT_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
      (per_q != '0) |-> (cnt_q < per_q)); // R6

endmodule

// File: rtl/clkratio_regs.sv
module clkratio_regs
   import clkratio_pkg::*;
#(
   parameter int              ADDR_W   = 12,
   parameter int              DATA_W   = 32,
   parameter logic [ADDR_W-1:0] REG_ADDR = 12'hA08
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [ADDR_W-1:0]                 bus_addr,
   input  logic                              bus_wr,
   input  logic [DATA_W-1:0]                 bus_wdata,
   output logic [DATA_W-1:0]                 bus_rdata,
   output logic [NUM_GROUPS-1:0][RATIO_W-1:0] ratio_req
);

   logic [DATA_W-1:0] store_q;
   logic              err_q;
   logic              hit;
   logic              we;
   logic              clr;
   logic              conflict;
   ratio_t            crypto_code;
   ratio_t            usb_code;

   assign hit = (bus_addr == REG_ADDR);
   assign we  = bus_wr && hit;
   assign clr = we && bus_wdata[FLAG_BIT];

   assign crypto_code = store_q[UNIT_BASE +: RATIO_W];
   assign usb_code    = store_q[UNIT_BASE + UNIT_STRIDE +: RATIO_W];
   assign conflict    = (crypto_code != '0) && (usb_code != '0) &&
                        (crypto_code != usb_code);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         store_q <= RESET_VALUE;
         err_q   <= 1'b0;
      end else begin
         if (we)
            store_q <= bus_wdata & FIELD_MASK;
         err_q <= (err_q && !clr) || conflict;
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (hit) begin
         bus_rdata = store_q;
         bus_rdata[FLAG_BIT] = err_q;
      end
   end

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_decode
      if (g < NET_GROUPS) begin : g_net
         assign ratio_req[g] = net_ratio(store_q[NET_CODE_LSB +: RATIO_W],
                                         store_q[NET_ON_LSB + g]);
      end else begin : g_unit
         assign ratio_req[g] = store_q[UNIT_BASE + UNIT_STRIDE*(g-NET_GROUPS) +: RATIO_W];
      end
   end

   AST_RESERVED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rdata & ~(FIELD_MASK | (32'h1 << FLAG_BIT))) == '0); // R2

   AST_FOREIGN_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !hit) |=> $stable(store_q)); // R1

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (err_q && !clr) |=> err_q); // R8

   AST_FLAG_SETS_ON_CONFLICT: assert property (@(posedge clk) disable iff (!rst_n)
      conflict |=> err_q); // R9

endmodule

// File: rtl/clkratio_ctrl.sv
module clkratio_ctrl
   import clkratio_pkg::*;
#(
   parameter int                ADDR_W   = 12,
   parameter int                DATA_W   = 32,
   parameter logic [ADDR_W-1:0] REG_ADDR = 12'hA08
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              net0_ce,
   output logic              net1_ce,
   output logic              crypto_ce,
   output logic              usb_ce
);

   if (DATA_W != 32) begin : g_bad_data_w
      $error("clkratio_ctrl: DATA_W must be 32");
   end
   if (ADDR_W < 1 || ADDR_W > 32) begin : g_bad_addr_w
      $error("clkratio_ctrl: ADDR_W out of range");
   end

   logic [NUM_GROUPS-1:0][RATIO_W-1:0] ratio_req;
   logic [NUM_GROUPS-1:0]              group_ce;

   clkratio_regs #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .REG_ADDR (REG_ADDR)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .ratio_req (ratio_req)
   );

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_div
      clkratio_divider #(
         .RW (RATIO_W)
      ) u_div (
         .clk       (clk),
         .rst_n     (rst_n),
         .ratio_req (ratio_req[g]),
         .ce        (group_ce[g])
      );
   end

   assign net0_ce   = group_ce[0];
   assign net1_ce   = group_ce[1];
   assign crypto_ce = group_ce[2];
   assign usb_ce    = group_ce[3];

endmodule

// File: tb/clkratio_ctrl_test.sv
`timescale 1ns/1ps
module clkratio_ctrl_test;

   localparam logic [11:0] RA   = 12'hA08;
   localparam logic [31:0] CLR  = 32'h8000_0000;
   localparam int          NVEC = 12;

   // stimulus word, and expected {flag, net0, net1, crypto, usb} pulses per 12 cycles
   localparam logic [31:0] VDATA [NVEC] = '{
      32'h0000_044D, 32'h0000_044E, 32'h0000_044F, 32'h0000_044C,
      32'h0000_0449, 32'h0000_0446, 32'h0000_000D, 32'h0000_088D,
      32'h0000_0C8D, 32'h0000_00CD, 32'h0000_080D, 32'h7FFF_FFFF };
   localparam logic [16:0] VEXP [NVEC] = '{
      17'h0CCCC, 17'h066CC, 17'h044CC, 17'h0CCCC,
      17'h00CCC, 17'h060CC, 17'h0CC00, 17'h0CC66,
      17'h1CC64, 17'h0CC40, 17'h0CC06, 17'h04444 };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] bus_addr = RA;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        net0_ce, net1_ce, crypto_ce, usb_ce;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   clkratio_ctrl uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .net0_ce(net0_ce),
      .net1_ce(net1_ce), .crypto_ce(crypto_ce), .usb_ce(usb_ce));

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr  = a;
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(negedge clk);
      bus_wr    = 1'b0;
      bus_addr  = RA;
   endtask

   task automatic settle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic count12(output int c0, output int c1, output int c2, output int c3);
      c0 = 0; c1 = 0; c2 = 0; c3 = 0;
      for (int i = 0; i < 12; i++) begin
         @(negedge clk);
         c0 += int'(net0_ce);
         c1 += int'(net1_ce);
         c2 += int'(crypto_ce);
         c3 += int'(usb_ce);
      end
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin : main
      int c0, c1, c2, c3;
      logic [31:0] last_val;

      // reset state
      settle(2);
      check("R1 reset readback", bus_rdata, 32'h0000_044D);
      check("R6 enables low in reset", {28'h0, net0_ce, net1_ce, crypto_ce, usb_ce}, 32'h0);
      rst_n = 1'b1;
      settle(2);
      check("R6 1:1 held high after reset", {28'h0, net0_ce, net1_ce, crypto_ce, usb_ce}, 32'hF);

      // table walk: write twice with clear so the flag reflects this vector only
      for (int v = 0; v < NVEC; v++) begin
         bus_write(RA, VDATA[v] | CLR);
         bus_write(RA, VDATA[v] | CLR);
         settle(8);
         check($sformatf("R2/R8/R10 readback vec %0d", v), bus_rdata,
               (VDATA[v] & 32'h0000_0CCF) | (32'(VEXP[v][16]) << 31));
         count12(c0, c1, c2, c3);
         check($sformatf("R3/R4/R6 net0 count vec %0d", v), 32'(c0), 32'(VEXP[v][15:12]));
         check($sformatf("R3/R4/R6 net1 count vec %0d", v), 32'(c1), 32'(VEXP[v][11:8]));
         check($sformatf("R5/R6 crypto count vec %0d", v), 32'(c2), 32'(VEXP[v][7:4]));
         check($sformatf("R5/R6 usb count vec %0d", v), 32'(c3), 32'(VEXP[v][3:0]));
      end

      // R1: foreign address
      last_val = bus_rdata;
      bus_write(RA + 12'h004, 32'h0000_0000);
      settle(2);
      check("R1 foreign write ignored", bus_rdata, last_val);
      bus_addr = RA + 12'h004;
      #1;
      check("R1 foreign read zero", bus_rdata, 32'h0);
      bus_addr = RA;

      // R7: ratio change mid-period
      bus_write(RA, CLR | 32'h0000_0CCF);
      settle(8);
      while (!net0_ce) @(negedge clk);
      bus_write(RA, CLR | 32'h0000_0CCD);
      check("R7 change: no early pulse", 32'(net0_ce), 32'h0);
      @(negedge clk);
      check("R7 change: old period completes", 32'(net0_ce), 32'h1);
      @(negedge clk);
      check("R7 change: new 1:1 in force", 32'(net0_ce), 32'h1);
      @(negedge clk);
      check("R7 change: 1:1 held", 32'(net0_ce), 32'h1);

      // R7: stop mid-period still delivers the closing pulse
      bus_write(RA, CLR | 32'h0000_0CCF);
      settle(8);
      while (!net0_ce) @(negedge clk);
      bus_write(RA, CLR | 32'h0000_0CCB);
      check("R7 stop: no early pulse", 32'(net0_ce), 32'h0);
      @(negedge clk);
      check("R7 stop: final pulse delivered", 32'(net0_ce), 32'h1);
      count12(c0, c1, c2, c3);
      check("R7 stop: stream stopped", 32'(c0), 32'h0);
      check("R4 stop: other network stream still 1:3", 32'(c1), 32'h4);

      // R8 / R9 flag sequences
      bus_write(RA, CLR | 32'h0000_084D);
      settle(3);
      check("R8 conflict sets flag", 32'(bus_rdata[31]), 32'h1);
      bus_write(RA, CLR | 32'h0000_084D);
      settle(3);
      check("R9 clear with conflict stored re-sets", 32'(bus_rdata[31]), 32'h1);
      bus_write(RA, 32'h0000_044D);
      settle(3);
      check("R8 flag sticky after conflict removed", 32'(bus_rdata[31]), 32'h1);
      check("R9 write of 0 to bit 31 keeps flag", bus_rdata, 32'h8000_044D);
      bus_write(RA, CLR | 32'h0000_044D);
      settle(3);
      check("R9 clear removes flag", bus_rdata, 32'h0000_044D);

      summary();
   end

endmodule